// File: doc/BRIEF.md
# Page-Mode Memory Bus Cycle Sequencer

This block sets the length, in clock cycles, of each processor bus transaction on a system whose main memory is DRAM run in page mode. Every request names what kind of transfer it is (instruction fetch, data read, data write or port I/O), a 16-bit address and the region it targets. The sequencer remembers which 256-byte DRAM row is open and what kind of DRAM transfer came last. From that it decides whether the new transfer can reuse the open row (fast) or must reopen it (slow). After the chosen number of cycles it raises a one-cycle completion pulse.

A page reopen is triggered by more than a change of row number. It is also needed when the stream turns from instruction fetch to data or back, when the data direction turns between read and write, and on the first fetch after a taken jump. The processor marks that fetch with a flag that travels with the request. Slow internal ROM and port I/O take fixed times and leave the DRAM row state alone. The expansion-slot region pays the DRAM-style cost plus a fixed wait.

Top module: `pgbus_sequencer`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and no row is open, so the first DRAM-style transfer takes the slow cost (2 cycles).
- R2: A DRAM transfer (`req_region` 0) of the same kind class as the previous DRAM-style transfer, to the open row (address bits 15:8), takes 1 cycle. Fetch addresses within the row need not be consecutive.
- R3: A DRAM-style transfer to a row other than the open one takes 2 cycles.
- R4: Turning from instruction fetch (`req_kind` 0) to data (`req_kind` 1 read, 2 write), or from data back to fetch, takes 2 cycles even when the row is unchanged.
- R5: A data write after a data read, or a data read after a data write, takes 2 cycles even to the same address.
- R6: A fetch presented with `req_jump` = 1 takes 2 cycles regardless of row. `req_jump` has no effect on data transfers.
- R7: A non-I/O transfer to slow internal ROM (`req_region` 1) takes 3 cycles whether or not the row changes, and leaves the open-row state unchanged.
- R8: A port I/O transfer (`req_kind` 3) takes 8 cycles in any region and leaves the open-row state unchanged.
- R9: A non-I/O transfer to the expansion slot (`req_region` 3) takes its DRAM-style cost (1 or 2) plus 2 wait cycles, and updates the open-row state.
- R10: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `done` is high for exactly one cycle, N cycles after that edge, where a 1-cycle transfer shows `done` in the first cycle. `req_ready` stays 0 from acceptance through the `done` cycle and returns to 1 in the cycle after. Requests presented while `req_ready` is 0 are ignored.
- R11: ROM in DRAM mode (`req_region` 2) is timed and tracked exactly like DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 I/O |
| req_region | input | 2 | 0 DRAM, 1 slow ROM, 2 ROM in DRAM mode, 3 expansion slot |
| req_addr | input | 16 | Transfer address |
| req_jump | input | 1 | Fetch is the first one after a taken jump |
| done | output | 1 | One-cycle pulse when the transfer's cycles are used up |

## Verification
The bench walks one transfer stream through every cause of a row reopen and measures each transfer's length in cycles. The causes are a cold start, a row change, a fetch/data turn, a read/write turn and a jump flag. A sequencer that keyed only on row number would return 1 where 2 is due on the class and direction turns. The bench also checks that ROM and I/O leave the open row untouched: a tracker that let them overwrite the row would make the next DRAM fetch slow. Requests held high while busy must not be taken. A sequencer that took one would stretch or repeat the completion and would disturb the row state that the following transfer reveals.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_IO    = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RG_DRAM = 2'd0,
    RG_ROM  = 2'd1,
    RG_ROMD = 2'd2,
    RG_EXT  = 2'd3
  } region_e;
endpackage

// File: rtl/pgbus_page_tracker.sv
module pgbus_page_tracker
  import pgbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [1:0]    kind,
  input  logic [1:0]    region,
  input  logic [AW-1:0] addr,
  input  logic          jump,
  output logic          brk,
  output logic          uses_dram
);
  localparam int PLO = AW - PW;

  logic [PW-1:0] pg_q;
  logic          pg_vld_q;
  logic          was_fetch_q;
  logic          was_write_q;
  logic          is_fetch, is_write;
  logic          row_miss, class_turn, dir_turn, jump_hit;

  always_comb begin
    is_fetch   = (kind == K_FETCH);
    is_write   = (kind == K_WRITE);
    uses_dram  = (kind != K_IO) && (region != RG_ROM);
    row_miss   = !pg_vld_q || (addr[AW-1:PLO] != pg_q);
    class_turn = (is_fetch != was_fetch_q);
    dir_turn   = !is_fetch && !was_fetch_q && (is_write != was_write_q);
    jump_hit   = is_fetch && jump;
    brk        = row_miss || class_turn || dir_turn || jump_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q        <= '0;
      pg_vld_q    <= 1'b0;
      was_fetch_q <= 1'b0;
      was_write_q <= 1'b0;
    end else if (commit && uses_dram) begin
      pg_q        <= addr[AW-1:PLO];
      pg_vld_q    <= 1'b1;
      was_fetch_q <= is_fetch;
      was_write_q <= is_write;
    end
  end

  AST_COLD_ROW_MISS: assert property (@(posedge clk) disable iff (rst)
    !pg_vld_q |-> brk); // R1
  AST_JUMP_FORCES_BREAK: assert property (@(posedge clk) disable iff (rst)
    (kind == K_FETCH && jump) |-> brk); // R6
  AST_SIDE_ACCESS_KEEPS_ROW: assert property (@(posedge clk) disable iff (rst)
    (commit && !uses_dram) |=> ($stable(pg_q) && $stable(pg_vld_q) && $stable(was_fetch_q))); // R7
endmodule

// File: rtl/pgbus_cost_calc.sv
module pgbus_cost_calc
  import pgbus_pkg::*;
#(
  parameter int HIT_CYC  = 1,
  parameter int MISS_CYC = 2,
  parameter int ROM_CYC  = 3,
  parameter int IO_CYC   = 8,
  parameter int EXT_WAIT = 2,
  parameter int CW       = 4
) (
  input  logic [1:0]    kind,
  input  logic [1:0]    region,
  input  logic          brk,
  output logic [CW-1:0] cost
);
  logic [CW-1:0] dram_cost;

  always_comb begin
    dram_cost = brk ? CW'(MISS_CYC) : CW'(HIT_CYC);
    if (kind == K_IO) begin
      cost = CW'(IO_CYC);
    end else begin
      case (region)
        RG_ROM:  cost = CW'(ROM_CYC);
        RG_EXT:  cost = dram_cost + CW'(EXT_WAIT);
        default: cost = dram_cost;
      endcase
    end
  end
endmodule

// File: rtl/pgbus_cycle_counter.sv
module pgbus_cycle_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  input  logic [CW-1:0] cost,
  output logic          ready,
  output logic          accept,
  output logic          done
);
  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] rem_q;

  assign ready  = !busy_q;
  assign accept = start_valid && !busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      rem_q  <= cost - CW'(1);
      done_q <= (cost == CW'(1));
    end else if (busy_q) begin
      if (done_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        rem_q  <= rem_q - CW'(1);
        done_q <= (rem_q == CW'(1));
      end
    end
  end

  AST_COST_NONZERO: assert property (@(posedge clk) disable iff (rst)
    accept |-> (cost != '0)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R10
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> ready); // R10
  AST_DONE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !ready); // R10
endmodule

// File: rtl/pgbus_sequencer.sv
module pgbus_sequencer #(
  parameter int AW       = 16,
  parameter int PW       = 8,
  parameter int HIT_CYC  = 1,
  parameter int MISS_CYC = 2,
  parameter int ROM_CYC  = 3,
  parameter int IO_CYC   = 8,
  parameter int EXT_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [1:0]    req_region,
  input  logic [AW-1:0] req_addr,
  input  logic          req_jump,
  output logic          done
);
  localparam int EXT_MAX = MISS_CYC + EXT_WAIT;
  localparam int M1      = (IO_CYC > ROM_CYC) ? IO_CYC : ROM_CYC;
  localparam int MAXC    = (M1 > EXT_MAX) ? M1 : EXT_MAX;
  localparam int CW      = $clog2(MAXC + 1);

  logic          brk;
  logic          uses_dram;
  logic          accept;
  logic [CW-1:0] cost;

  pgbus_page_tracker #(.AW(AW), .PW(PW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .commit    (accept),
    .kind      (req_kind),
    .region    (req_region),
    .addr      (req_addr),
    .jump      (req_jump),
    .brk       (brk),
    .uses_dram (uses_dram)
  );

  pgbus_cost_calc #(
    .HIT_CYC (HIT_CYC), .MISS_CYC(MISS_CYC), .ROM_CYC(ROM_CYC),
    .IO_CYC  (IO_CYC),  .EXT_WAIT(EXT_WAIT), .CW(CW)
  ) u_cost (
    .kind   (req_kind),
    .region (req_region),
    .brk    (brk),
    .cost   (cost)
  );

  pgbus_cycle_counter #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .start_valid (req_valid),
    .cost        (cost),
    .ready       (req_ready),
    .accept      (accept),
    .done        (done)
  );

  AST_IO_FIXED_COST: assert property (@(posedge clk) disable iff (rst)
    (accept && req_kind == 2'd3) |-> (cost == CW'(IO_CYC))); // R8
  AST_ROM_FIXED_COST: assert property (@(posedge clk) disable iff (rst)
    (accept && req_kind != 2'd3 && req_region == 2'd1) |-> (cost == CW'(ROM_CYC))); // R7
  AST_EXT_ADDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    (accept && req_kind != 2'd3 && req_region == 2'd3) |-> (cost >= CW'(HIT_CYC + EXT_WAIT))); // R9
  AST_DRAM_COST_BOUND: assert property (@(posedge clk) disable iff (rst)
    (accept && uses_dram && req_region != 2'd3) |-> (cost <= CW'(MISS_CYC))); // R11
endmodule

// File: tb/tb_pgbus_sequencer.sv
`timescale 1ns/1ps
module tb_pgbus_sequencer;
  localparam logic [1:0] KF = 2'd0, KR = 2'd1, KW = 2'd2, KI = 2'd3;
  localparam logic [1:0] GD = 2'd0, GR = 2'd1, GM = 2'd2, GX = 2'd3;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [1:0]  req_region;
  logic [15:0] req_addr;
  logic        req_jump;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pgbus_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_region(req_region), .req_addr(req_addr),
    .req_jump(req_jump), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!req_ready && g < 50) begin
      @(negedge clk);
      g++;
    end
  endtask

  // One transfer: measures cycles to done, then checks the handshake release.
  task automatic xfer(input logic [1:0] k, input logic [1:0] rg, input logic [15:0] a,
                      input logic j, input int exp, input string tag);
    int n;
    wait_ready();
    req_kind = k; req_region = rg; req_addr = a; req_jump = j; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_jump = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp, tag, n, exp);
    @(negedge clk);
    chk(req_ready && !done, "R10 ready back, done one cycle", {req_ready, done}, 2);
  endtask

  // I/O transfer with a competing request held high while busy (R10, R8).
  task automatic held_off();
    int n;
    wait_ready();
    req_kind = KI; req_region = GD; req_addr = 16'h00A0; req_jump = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_kind = KF; req_region = GD; req_addr = 16'h7700; req_jump = 1'b1;
    n = 1;
    chk(!req_ready, "R10 ready low while busy", req_ready, 0);
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 4) begin
        req_valid = 1'b0;
        req_jump  = 1'b0;
      end
    end
    chk(n == 8, "R8 io length with held request R10", n, 8);
    @(negedge clk);
    chk(req_ready && !done, "R10 ready after io", {req_ready, done}, 2);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = KF; req_region = GD;
    req_addr = '0; req_jump = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done == 1'b0, "R1 done low after reset", done, 0);

    xfer(KF, GD, 16'h1000, 1'b0, 2, "R1 first access slow");
    xfer(KF, GD, 16'h1001, 1'b0, 1, "R2 fetch in row");
    xfer(KF, GD, 16'h1080, 1'b0, 1, "R2 noncontiguous fetch in row");
    xfer(KF, GD, 16'h1100, 1'b0, 2, "R3 fetch new row");
    xfer(KR, GD, 16'h11F0, 1'b0, 2, "R4 fetch to read same row");
    xfer(KR, GD, 16'h11F1, 1'b0, 1, "R2 second read same row");
    xfer(KR, GD, 16'h1200, 1'b0, 2, "R3 read crosses row");
    xfer(KW, GD, 16'h1200, 1'b0, 2, "R5 read to write same address");
    xfer(KW, GD, 16'h1201, 1'b0, 1, "R2 second write same row");
    xfer(KR, GD, 16'h1202, 1'b0, 2, "R5 write to read");
    xfer(KF, GD, 16'h1203, 1'b0, 2, "R4 data to fetch");
    xfer(KF, GD, 16'h1204, 1'b1, 2, "R6 jump forces break");
    xfer(KF, GD, 16'h1205, 1'b0, 1, "R6 after jump fast");
    xfer(KI, GD, 16'h0099, 1'b0, 8, "R8 io cost");
    xfer(KF, GD, 16'h1206, 1'b0, 1, "R8 io keeps row");
    held_off();
    xfer(KF, GD, 16'h1207, 1'b0, 1, "R10 held request ignored");
    xfer(KF, GR, 16'h0000, 1'b0, 3, "R7 rom fetch");
    xfer(KR, GR, 16'h0001, 1'b0, 3, "R7 rom read same row");
    xfer(KR, GR, 16'h05FF, 1'b0, 3, "R7 rom read other row");
    xfer(KF, GD, 16'h1208, 1'b0, 1, "R7 rom keeps row");
    xfer(KF, GM, 16'h1209, 1'b0, 1, "R11 dram-mode rom fast");
    xfer(KR, GM, 16'h3000, 1'b0, 2, "R11 dram-mode rom slow");
    xfer(KR, GX, 16'h4000, 1'b0, 4, "R9 ext miss plus wait");
    xfer(KR, GX, 16'h4001, 1'b0, 3, "R9 ext hit plus wait");
    xfer(KR, GD, 16'h4002, 1'b1, 1, "R6 jump flag ignored on data");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule